// File: doc/BRIEF.md
# I2C Target Register Port

This block is an I2C target that runs from a fast system clock, at least 16 times the SCL rate. The bus lines pass through synchronisers, and start, repeated start and stop are detected on the synchronised signals. The block then moves bytes between the bus and an 8-bit register space through a plain register-file interface. That interface has a pointer address, write data, a write strobe, a read strobe and read data. The read data must be valid on the cycle after the read strobe, which suits a registered or block-RAM register file.

The target answers one 7-bit address: the fixed upper bits 1,0,1,1,0, then strap pin 1 as address bit 2 and strap pin 0 as address bit 1. A write transfer sets the register pointer and writes one data byte. A read transfer first sets the pointer in a write phase. It then reopens the bus with a repeated start, or with a stop and a fresh start, and streams registers for as long as the master acknowledges. One register address and value pair is decoded as a software-reset command.

Top module: `i2cs_regport`

## Requirements
- R1: After reset the target does not drive SDA (sda_oe = 0) and reg_we, reg_re and soft_rst are all 0.
- R2: An address byte whose upper seven bits equal {1,0,1,1,0, strap_i[1], strap_i[0]} is acknowledged: sda_oe pulls SDA low during the ninth clock. The byte's bit 0 selects read (1) or write (0). Changing the straps changes the answered address.
- R3: An address byte that does not match gets no acknowledge. The target then leaves SDA released and makes no register access until the next start condition.
- R4: In a write transfer, the byte after the address is loaded as the register pointer and acknowledged. The byte after that, received MSB first, produces exactly one reg_we pulse with reg_addr equal to the pointer and reg_wdata equal to the byte, and it is acknowledged.
- R5: Any further data byte in the same write transfer gets no acknowledge and produces no reg_we pulse.
- R6: A read address, reached either by a repeated start or by a stop and a new start, causes one reg_re pulse at the current pointer. The returned register value is then shifted out MSB first.
- R7: When the master acknowledges a byte the target sent, the pointer increments by one, a reg_re pulse fetches the next register, and that value is sent next.
- R8: When the master does not acknowledge a byte the target sent, no further reg_re occurs and SDA stays released until the next start or stop.
- R9: A start or stop condition in the middle of a byte abandons that byte. No reg_we is produced for it, and a following complete transfer works normally.
- R10: Writing data 0x00 to register address 0x7F produces a soft_rst pulse exactly one clock long, in the same cycle as its reg_we. Any other value written to 0x7F gives no pulse.
- R11: The target changes sda_oe only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired, includes own drive) |
| strap_i | input | 2 | Address straps: [1] is address bit 2, [0] is address bit 1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_re |
| soft_rst | output | 1 | One-cycle software-reset pulse |

## Verification
A table of pointer and data pairs is written and then read back through a repeated start. The table includes the all-ones byte and a non-reset value at the reset register, which separates correct MSB-first shifting, pointer loading and a falsely triggered reset. Directed transfers cover:
- a streaming read with ACK, ACK and NACK, which shows the pointer incrementing and no fetch after the NACK;
- a read reopened by stop and start instead of a repeated start;
- a wrong address, an extra write byte, and a byte cut off by a stop or by a start;
- a change of the straps, which moves the answered address.

The true software-reset write is checked for a single pulse that is exactly one clock wide.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_REG,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      scl_lvl  <= 1'b1;
      sda_lvl  <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      start_p  <= 1'b0;
      stop_p   <= 1'b0;
    end else begin
      scl_q    <= scl_s;
      sda_q    <= sda_s;
      scl_lvl  <= scl_s;
      sda_lvl  <= sda_s;
      scl_rise <= scl_s & ~scl_q;
      scl_fall <= ~scl_s & scl_q;
      start_p  <= scl_s & scl_q & sda_q & ~sda_s;
      stop_p   <= scl_s & scl_q & ~sda_q & sda_s;
    end
  end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [DATA_W-4:0] PREFIX  = 5'b10110,
  parameter logic [ADDR_W-1:0] RESET_REG = 8'h7F,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [1:0]        strap,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic              soft_rst
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  phase_t            phase, ph_next;
  logic [CNT_W-1:0]  cnt;
  logic              in_ack;
  logic              mack;
  logic              cap;
  logic [DATA_W-1:0] sh, tx;
  logic [DATA_W-2:0] dev;

  assign dev = {PREFIX, strap};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      ph_next   <= PH_IDLE;
      cnt       <= '0;
      in_ack    <= 1'b0;
      mack      <= 1'b0;
      cap       <= 1'b0;
      sh        <= '0;
      tx        <= '0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      soft_rst  <= 1'b0;
    end else begin
      reg_we   <= 1'b0;
      reg_re   <= 1'b0;
      soft_rst <= 1'b0;
      cap      <= reg_re;
      if (cap) tx <= reg_rdata;

      if (start_p) begin
        phase  <= PH_ADDR;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (phase == PH_RD) begin
        // target transmits, master acknowledges
        if (scl_rise) begin
          if (in_ack) begin
            mack <= ~sda_lvl;
            if (!sda_lvl) begin
              reg_addr <= reg_addr + 1'b1;
              reg_re   <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            if (mack) begin
              sda_oe <= ~tx[DATA_W-1];
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_SKIP;
            end
          end else if (cnt == FULL) begin
            sda_oe <= 1'b0;
            in_ack <= 1'b1;
          end else if (cnt != '0) begin
            sda_oe <= ~tx[DATA_W-2];
            tx     <= tx << 1;
          end
        end
      end else if (phase == PH_ADDR || phase == PH_REG || phase == PH_WR) begin
        // target receives and acknowledges
        if (scl_rise && !in_ack && cnt < FULL) begin
          sh  <= {sh[DATA_W-2:0], sda_lvl};
          cnt <= cnt + 1'b1;
        end else if (scl_fall && in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          phase  <= ph_next;
          sda_oe <= (ph_next == PH_RD) ? ~tx[DATA_W-1] : 1'b0;
        end else if (scl_fall && cnt == FULL) begin
          case (phase)
            PH_ADDR: begin
              if (sh[DATA_W-1:1] == dev) begin
                sda_oe  <= 1'b1;
                in_ack  <= 1'b1;
                ph_next <= sh[0] ? PH_RD : PH_REG;
                if (sh[0]) reg_re <= 1'b1;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_REG: begin
              reg_addr <= sh[ADDR_W-1:0];
              sda_oe   <= 1'b1;
              in_ack   <= 1'b1;
              ph_next  <= PH_WR;
            end
            default: begin
              reg_we    <= 1'b1;
              reg_wdata <= sh;
              soft_rst  <= (reg_addr == RESET_REG) && (sh == RESET_VAL);
              sda_oe    <= 1'b1;
              in_ack    <= 1'b1;
              ph_next   <= PH_SKIP;
            end
          endcase
        end
      end
    end
  end

  // R10: the reset pulse accompanies the matching register write
  a_r10_soft_with_write: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (reg_we && reg_addr == RESET_REG && reg_wdata == RESET_VAL));

  // R10: the reset pulse lasts a single cycle
  a_r10_soft_one_cycle: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  // R11: SDA drive changes only while SCL is low (bus conditions excepted)
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_p) && !$past(stop_p)) |-> !scl_lvl);

  // R4: register writes are committed while SCL is low
  a_r4_we_scl_low: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !scl_lvl);

  // R3, R8: an ignoring target keeps SDA released
  a_r8_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> !sda_oe);

  // R6: no cycle both reads and writes the register file
  a_r6_we_re_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  // R2: bit counter never passes one byte
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

endmodule

// File: rtl/i2cs_regport.sv
module i2cs_regport #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              soft_rst
);

  logic [1:0] bus_s;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;

  i2cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_i, sda_i}),
    .dout (bus_s)
  );

  i2cs_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (bus_s[1]),
    .sda_s    (bus_s[0]),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  i2cs_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .strap     (strap_i),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .soft_rst  (soft_rst)
  );

endmodule

// File: tb/i2cs_regport_bench.sv
module i2cs_regport_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, reg_we, reg_re, soft_rst;
  logic [7:0] reg_addr, reg_wdata, rdata;
  logic [7:0] mem [256];
  wire  sda_line = sda_m & ~sda_oe;

  int n_run = 0, n_fail = 0;
  int we_cnt = 0, re_cnt = 0, soft_cnt = 0, soft_wide = 0, oe_bad = 0;
  logic [7:0] last_wa = 8'h00, last_wd = 8'h00;
  logic soft_prev = 1'b0, oe_prev = 1'b0;

  always #10 clk = ~clk;

  i2cs_regport u_i2cs_regport (
    .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (sda_line),
    .strap_i (strap), .sda_oe (sda_oe), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_we (reg_we), .reg_re (reg_re),
    .reg_rdata (rdata), .soft_rst (soft_rst)
  );

  // register file model with one-cycle read latency
  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) rdata <= mem[reg_addr];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) begin we_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
      if (reg_re) re_cnt++;
      if (soft_rst) begin soft_cnt++; if (soft_prev) soft_wide++; end
      if (sda_oe != oe_prev && scl_m) oe_bad++;
    end
    soft_prev = soft_rst;
    oe_prev   = sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(10); scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10); scl_m = 1'b0; tick(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(10); scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(20);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(10); scl_m = 1'b1; tick(20); scl_m = 1'b0; tick(10);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(10); scl_m = 1'b1; tick(10);
    b = sda_line; tick(10); scl_m = 1'b0; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~mack);
  endtask

  function automatic logic [7:0] dev(input logic [1:0] s, input logic rw);
    return {5'b10110, s, rw};
  endfunction

  task automatic wr_txn(input logic [7:0] dv, input logic [7:0] a, input logic [7:0] d,
                        output logic k0, output logic k1, output logic k2);
    bus_start();
    send_byte(dv, k0);
    send_byte(a, k1);
    send_byte(d, k2);
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] a, output logic [7:0] d);
    logic k;
    bus_start();
    send_byte(dev(strap, 1'b0), k);
    send_byte(a, k);
    bus_start();
    send_byte(dev(strap, 1'b1), k);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  // {register, data, expected soft-reset pulses}
  localparam logic [23:0] VEC [4] = '{
    {8'h10, 8'hA5, 8'd0},
    {8'h11, 8'h3C, 8'd0},
    {8'h12, 8'hFF, 8'd0},
    {8'h7F, 8'h5A, 8'd0}
  };

  initial begin
    logic k0, k1, k2;
    logic [7:0] d0, d1, d2, d3;
    int w0, r0, s0;

    tick(5);
    rst = 1'b0;
    tick(3);
    @(negedge clk);
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 strobes after reset", {reg_we, reg_re, soft_rst}, 0);
    tick(1);

    for (int v = 0; v < 4; v++) begin
      w0 = we_cnt; s0 = soft_cnt;
      wr_txn(dev(strap, 1'b0), VEC[v][23:16], VEC[v][15:8], k0, k1, k2);
      check("R2 address ack", k0, 1);
      check("R4 acks on pointer and data", {k1, k2}, 2'b11);
      check("R4 one write strobe", we_cnt - w0, 1);
      check("R4 write address/data", {last_wa, last_wd}, VEC[v][23:8]);
      check("R10 no reset for this write", soft_cnt - s0, VEC[v][7:0]);
      rd_txn(VEC[v][23:16], d0);
      check("R6 readback value", d0, VEC[v][15:8]);
    end

    // R7 / R8: streaming read, ack ack nack, then extra clocks
    r0 = re_cnt;
    bus_start();
    send_byte(dev(strap, 1'b0), k0);
    send_byte(8'h10, k0);
    bus_start();
    send_byte(dev(strap, 1'b1), k0);
    recv_byte(d0, 1'b1);
    recv_byte(d1, 1'b1);
    recv_byte(d2, 1'b0);
    recv_byte(d3, 1'b0);
    bus_stop();
    check("R7 stream byte 0", d0, 8'hA5);
    check("R7 stream byte 1", d1, 8'h3C);
    check("R7 stream byte 2", d2, 8'hFF);
    check("R8 bus released after nack", d3, 8'hFF);
    check("R8 reads stop after nack", re_cnt - r0, 3);

    // R6: read reopened by stop then start
    bus_start();
    send_byte(dev(strap, 1'b0), k0);
    send_byte(8'h11, k1);
    bus_stop();
    bus_start();
    send_byte(dev(strap, 1'b1), k2);
    recv_byte(d0, 1'b0);
    bus_stop();
    check("R6 stop-start read ack", {k0, k1, k2}, 3'b111);
    check("R6 stop-start read value", d0, 8'h3C);

    // R3: wrong address
    w0 = we_cnt;
    wr_txn({5'b10110, 2'b00, 1'b0}, 8'h40, 8'h99, k0, k1, k2);
    check("R3 no ack on mismatch", {k0, k1, k2}, 3'b000);
    check("R3 no write on mismatch", we_cnt - w0, 0);

    // R5: extra data byte
    w0 = we_cnt;
    bus_start();
    send_byte(dev(strap, 1'b0), k0);
    send_byte(8'h20, k0);
    send_byte(8'h11, k1);
    send_byte(8'h22, k2);
    bus_stop();
    check("R5 extra byte nacked", {k1, k2}, 2'b10);
    check("R5 single write", we_cnt - w0, 1);
    check("R5 written pair", {last_wa, last_wd}, 16'h2011);

    // R9: stop inside a data byte
    w0 = we_cnt;
    bus_start();
    send_byte(dev(strap, 1'b0), k0);
    send_byte(8'h30, k0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check("R9 stop abort no write", we_cnt - w0, 0);

    // R9: start inside a data byte, then a full write
    bus_start();
    send_byte(dev(strap, 1'b0), k0);
    send_byte(8'h30, k0);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    wr_txn(dev(strap, 1'b0), 8'h31, 8'h77, k0, k1, k2);
    check("R9 restart abort then one write", we_cnt - w0, 1);
    check("R9 write after abort", {last_wa, last_wd}, 16'h3177);

    // R10: real software reset
    s0 = soft_cnt;
    wr_txn(dev(strap, 1'b0), 8'h7F, 8'h00, k0, k1, k2);
    check("R10 one reset pulse", soft_cnt - s0, 1);
    check("R10 pulse one cycle wide", soft_wide, 0);

    // R2: straps move the address
    strap = 2'b01;
    tick(4);
    w0 = we_cnt;
    wr_txn({5'b10110, 2'b10, 1'b0}, 8'h50, 8'h12, k0, k1, k2);
    check("R2 old address ignored", k0, 0);
    wr_txn(dev(strap, 1'b0), 8'h50, 8'h34, k0, k1, k2);
    check("R2 new address acked", k0, 1);
    check("R2 only new address writes", we_cnt - w0, 1);

    check("R11 sda drive changes only with scl low", oe_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule